// File: doc/BRIEF.md
# Multicycle Accumulator Processor Controller

This block is a small 16-bit processor with one accumulator and one memory that holds both code and data. Every instruction names a single memory operand. The accumulator is both the implicit second operand and the destination. The processor has one address bus and one data bus. A synchronous single-port memory sits outside the block, and the block drives it through a read strobe and a write strobe.

A Moore state machine steps each instruction through the same phases:
- Fetch: the word is read into the instruction register.
- Decode: the opcode picks the next path.
- Execute: the path depends on the instruction class.

Arithmetic and load instructions take a data-read path. Stores take a write path. Branches either load the program counter or return straight to fetch. Every memory access is staged through an address register and a data register. The program counter advances through the ALU, not through its own adder. The highest address is decoded as an output display register, not as ordinary storage.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `mem_re`, `mem_we` and `disp_out` are all 0. After reset is released, the first memory access is a read of address 0.
- R2: Each fetch reads the word at the program counter. When no branch is taken, the next fetch reads the following address, and the address wraps modulo 2^ADDR_W.
- R3: An instruction word has its opcode in bits 15:12 and its operand address in bits 7:0. The codes are 0 ADD, 1 SUB, 2 AND, 3 LOAD, 4 STORE, 5 BRZ, 6 BRN and 7 JMP. Any other opcode changes nothing except the program counter.
- R4: ADD, SUB and AND set AC to AC+M, AC-M and AC&M, where M is the operand word. Results wrap modulo 2^16.
- R5: LOAD copies the operand word into AC.
- R6: STORE asserts `mem_we` for exactly one cycle, with `mem_addr` set to the operand address and `mem_wdata` set to AC.
- R7: Every instruction that writes AC also sets the flags: N takes AC bit 15, and Z is set when AC is 0. BRZ jumps to its address when Z is set, and BRN jumps when N is set. Otherwise execution continues at the next address.
- R8: JMP always continues at its address.
- R9: A STORE to address 2^ADDR_W-1 updates `disp_out` and raises no `mem_we`. A LOAD from that address returns the display value, not the memory word.
- R10: The gap from one fetch read strobe to the next is fixed by class: 9 cycles for ADD, SUB, AND and LOAD; 7 for STORE; 6 for a taken branch or JMP; 5 for a branch not taken or an undefined opcode. The data read or write strobe comes 5 cycles after the fetch read strobe.
- R11: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory address, driven from the address register |
| mem_re | output | 1 | Read strobe; read data is returned the following cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data, driven from the data register |
| mem_rdata | input | DATA_W | Read data from the memory |
| disp_out | output | DATA_W | Memory-mapped display register |

## Verification
The bench builds the block with its defaults, DATA_W=16 and ADDR_W=8. With these values the display address is 0xFF, which a short program can reach. Arithmetic wrap at 16 bits and a negative result in bit 15 each take a single instruction. The bench records every memory strobe with its cycle number. It then compares the whole access sequence against a hand-computed trace. This covers taken and not-taken branches, undefined opcodes, writes suppressed at the display address, and the fixed per-class cycle spacing.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h0;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'h1;
    localparam logic [OPC_W-1:0] OPC_AND   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h3;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h4;
    localparam logic [OPC_W-1:0] OPC_BRZ   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_BRN   = 4'h6;
    localparam logic [OPC_W-1:0] OPC_JMP   = 4'h7;

    typedef enum logic [3:0] {
        S_INIT,
        S_FETCH,
        S_FREAD,
        S_FCAP,
        S_IRLD,
        S_DECODE,
        S_DADDR,
        S_DREAD,
        S_DCAP,
        S_EXEC,
        S_SADDR,
        S_SWRITE,
        S_BRTAKE
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_PASS,
        ALU_INC
    } alu_op_e;

    typedef struct packed {
        logic    init;
        logic    mar_pc;
        logic    mar_ir;
        logic    mdr_mem;
        logic    mdr_ac;
        logic    ir_ld;
        logic    pc_inc;
        logic    pc_br;
        logic    ac_ld;
        logic    disp_wr;
        logic    mem_re;
        logic    mem_we;
        alu_op_e alu_op;
    } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] y_o,
    output logic              neg_o,
    output logic              zero_o
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_SUB:  y_o = a_i - b_i;
            ALU_AND:  y_o = a_i & b_i;
            ALU_PASS: y_o = b_i;
            ALU_INC:  y_o = a_i + ONE;
            default:  y_o = b_i;
        endcase
    end

    assign neg_o  = y_o[DATA_W-1];
    assign zero_o = (y_o == '0);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             flag_n_i,
    input  logic             flag_z_i,
    output ctl_t             ctl_o
);

    typedef struct packed {
        state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    // next-state logic
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            S_INIT:   seq_d.st = S_FETCH;
            S_FETCH:  seq_d.st = S_FREAD;
            S_FREAD:  seq_d.st = S_FCAP;
            S_FCAP:   seq_d.st = S_IRLD;
            S_IRLD:   seq_d.st = S_DECODE;
            S_DECODE: begin
                unique case (opcode_i)
                    OPC_ADD, OPC_SUB, OPC_AND, OPC_LOAD: seq_d.st = S_DADDR;
                    OPC_STORE: seq_d.st = S_SADDR;
                    OPC_JMP:   seq_d.st = S_BRTAKE;
                    OPC_BRZ:   seq_d.st = flag_z_i ? S_BRTAKE : S_FETCH;
                    OPC_BRN:   seq_d.st = flag_n_i ? S_BRTAKE : S_FETCH;
                    default:   seq_d.st = S_FETCH;
                endcase
            end
            S_DADDR:  seq_d.st = S_DREAD;
            S_DREAD:  seq_d.st = S_DCAP;
            S_DCAP:   seq_d.st = S_EXEC;
            S_EXEC:   seq_d.st = S_FETCH;
            S_SADDR:  seq_d.st = S_SWRITE;
            S_SWRITE: seq_d.st = S_FETCH;
            S_BRTAKE: seq_d.st = S_FETCH;
            default:  seq_d.st = S_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_INIT};
        else        seq_q <= seq_d;
    end

    // Moore outputs: depend only on the state and registered instruction
    always_comb begin
        ctl_o        = '0;
        ctl_o.alu_op = ALU_PASS;
        unique case (seq_q.st)
            S_INIT:   ctl_o.init    = 1'b1;
            S_FETCH:  ctl_o.mar_pc  = 1'b1;
            S_FREAD:  ctl_o.mem_re  = 1'b1;
            S_FCAP:   ctl_o.mdr_mem = 1'b1;
            S_IRLD: begin
                ctl_o.ir_ld  = 1'b1;
                ctl_o.pc_inc = 1'b1;
                ctl_o.alu_op = ALU_INC;
            end
            S_DADDR:  ctl_o.mar_ir  = 1'b1;
            S_DREAD:  ctl_o.mem_re  = 1'b1;
            S_DCAP:   ctl_o.mdr_mem = 1'b1;
            S_EXEC: begin
                ctl_o.ac_ld = 1'b1;
                unique case (opcode_i)
                    OPC_ADD: ctl_o.alu_op = ALU_ADD;
                    OPC_SUB: ctl_o.alu_op = ALU_SUB;
                    OPC_AND: ctl_o.alu_op = ALU_AND;
                    default: ctl_o.alu_op = ALU_PASS;
                endcase
            end
            S_SADDR: begin
                ctl_o.mar_ir = 1'b1;
                ctl_o.mdr_ac = 1'b1;
            end
            S_SWRITE: begin
                ctl_o.mem_we  = 1'b1;
                ctl_o.disp_wr = 1'b1;
            end
            S_BRTAKE: ctl_o.pc_br = 1'b1;
            default: ;
        endcase
    end

    p_fetch_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_FREAD) |=> (seq_q.st == S_FCAP));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_o.mem_re && ctl_o.mem_we));

    p_branch_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_DECODE && opcode_i == OPC_JMP) |=> (seq_q.st == S_BRTAKE));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] disp_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic              flag_n_o,
    output logic              flag_z_o
);

    localparam logic [ADDR_W-1:0] DISP_ADDR = {ADDR_W{1'b1}};
    localparam int                PAD_W     = DATA_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [OPC_W-1:0]  ir_op;
        logic [ADDR_W-1:0] ir_addr;
        logic [DATA_W-1:0] ac;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] disp;
        logic              n;
        logic              z;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [DATA_W-1:0] alu_a, alu_y;
    logic              alu_n, alu_z;
    logic              mar_is_disp;

    assign mar_is_disp = (rg_q.mar == DISP_ADDR);
    assign alu_a = ctl_i.pc_inc ? {{PAD_W{1'b0}}, rg_q.pc} : rg_q.ac;

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .a_i    (alu_a),
        .b_i    (rg_q.mdr),
        .op_i   (ctl_i.alu_op),
        .y_o    (alu_y),
        .neg_o  (alu_n),
        .zero_o (alu_z)
    );

    always_comb begin
        rg_d = rg_q;
        if (ctl_i.init) begin
            rg_d.pc = '0;
            rg_d.ac = '0;
            rg_d.n  = 1'b0;
            rg_d.z  = 1'b0;
        end
        if (ctl_i.mar_pc)  rg_d.mar = rg_q.pc;
        if (ctl_i.mar_ir)  rg_d.mar = rg_q.ir_addr;
        if (ctl_i.mdr_mem) rg_d.mdr = mar_is_disp ? rg_q.disp : mem_rdata_i;
        if (ctl_i.mdr_ac)  rg_d.mdr = rg_q.ac;
        if (ctl_i.ir_ld) begin
            rg_d.ir_op   = rg_q.mdr[DATA_W-1 -: OPC_W];
            rg_d.ir_addr = rg_q.mdr[ADDR_W-1:0];
        end
        if (ctl_i.pc_inc) rg_d.pc = alu_y[ADDR_W-1:0];
        if (ctl_i.pc_br)  rg_d.pc = rg_q.ir_addr;
        if (ctl_i.ac_ld) begin
            rg_d.ac = alu_y;
            rg_d.n  = alu_n;
            rg_d.z  = alu_z;
        end
        if (ctl_i.disp_wr && mar_is_disp) rg_d.disp = rg_q.mdr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign mem_addr_o  = rg_q.mar;
    assign mem_re_o    = ctl_i.mem_re;
    assign mem_we_o    = ctl_i.mem_we && !mar_is_disp;
    assign mem_wdata_o = rg_q.mdr;
    assign disp_o      = rg_q.disp;
    assign opcode_o    = rg_q.ir_op;
    assign flag_n_o    = rg_q.n;
    assign flag_z_o    = rg_q.z;

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.pc_inc |=> (rg_q.pc == $past(rg_q.pc) + 1'b1));

    p_store_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_wdata_o == rg_q.ac));

    p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rg_q.n && rg_q.z));

    p_no_disp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o != DISP_ADDR));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] disp_out
);

    ctl_t             ctl;
    logic [OPC_W-1:0] opcode;
    logic             flag_n, flag_z;

    acc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode),
        .flag_n_i (flag_n),
        .flag_z_i (flag_z),
        .ctl_o    (ctl)
    );

    acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .mem_rdata_i (mem_rdata),
        .mem_addr_o  (mem_addr),
        .mem_re_o    (mem_re),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .disp_o      (disp_out),
        .opcode_o    (opcode),
        .flag_n_o    (flag_n),
        .flag_z_o    (flag_z)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!mem_re && !mem_we && disp_out == '0));

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] disp_out;

    logic [15:0] mem [256];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int tr_n = 0;
    int tr_base = 0;
    int tr_cyc  [512];
    bit tr_we   [512];
    int tr_addr [512];
    int tr_dat  [512];

    always #4 clk = ~clk;

    acc_cpu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .disp_out  (disp_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (rst_n && (mem_re || mem_we) && tr_n < 512) begin
            tr_cyc[tr_n]  = cyc;
            tr_we[tr_n]   = mem_we;
            tr_addr[tr_n] = int'(mem_addr);
            tr_dat[tr_n]  = int'(mem_wdata);
            tr_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input int ncyc);
        tr_base = tr_n;
        rst_n = 1'b1;
        repeat (ncyc) @(negedge clk);
    endtask

    function automatic int gap(input int a, input int b);
        return tr_cyc[tr_base + b] - tr_cyc[tr_base + a];
    endfunction

    task automatic t_reset();
        hold_reset();
        mem[0] = 16'h7000;
        chk(mem_re == 1'b0, "R1 re in reset", int'(mem_re), 0);
        chk(mem_we == 1'b0, "R1 we in reset", int'(mem_we), 0);
        chk(disp_out == 16'h0, "R1 display in reset", int'(disp_out), 0);
        run(30);
        chk(tr_addr[tr_base] == 0 && !tr_we[tr_base], "R1 first access", tr_addr[tr_base], 0);
        chk(tr_addr[tr_base + 1] == 0, "R8 jmp to self", tr_addr[tr_base + 1], 0);
        chk(gap(0, 1) == 6, "R10 jmp spacing", gap(0, 1), 6);
    endtask

    task automatic t_arith();
        int ea [13] = '{0, 'h20, 1, 'h21, 2, 'h22, 3, 'h23, 4, 'h30, 5, 6, 6};
        hold_reset();
        mem[0] = 16'h3020;
        mem[1] = 16'h0021;
        mem[2] = 16'h1022;
        mem[3] = 16'h2023;
        mem[4] = 16'h4030;
        mem[5] = 16'h40FF;
        mem[6] = 16'h7006;
        mem['h20] = 16'h7FF0;
        mem['h21] = 16'h8020;
        mem['h22] = 16'h0011;
        mem['h23] = 16'hF0F0;
        mem['hFF] = 16'h1234;
        run(120);
        for (int i = 0; i < 13; i++)
            chk(tr_addr[tr_base + i] == ea[i] && tr_we[tr_base + i] == (i == 9),
                "R2 access sequence", tr_addr[tr_base + i], ea[i]);
        chk(tr_dat[tr_base + 9] == 'hF0F0, "R6 store data", tr_dat[tr_base + 9], 'hF0F0);
        chk(mem['h30] == 16'hF0F0, "R4 add wrap sub borrow and", int'(mem['h30]), 'hF0F0);
        chk(disp_out == 16'hF0F0, "R9 display store", int'(disp_out), 'hF0F0);
        chk(mem['hFF] == 16'h1234, "R9 top word untouched", int'(mem['hFF]), 'h1234);
        chk(gap(0, 1) == 5, "R10 data read offset", gap(0, 1), 5);
        chk(gap(0, 2) == 9, "R10 alu spacing", gap(0, 2), 9);
        chk(gap(8, 9) == 5, "R10 write offset", gap(8, 9), 5);
        chk(gap(8, 10) == 7, "R10 store spacing", gap(8, 10), 7);
        chk(gap(10, 11) == 7, "R10 display store spacing", gap(10, 11), 7);
    endtask

    task automatic t_branch();
        int ea [17] = '{0, 'h20, 1, 4, 'h21, 5, 6, 8, 'h22, 9, 10, 11, 12, 13, 'h42, 14, 14};
        hold_reset();
        mem[0]  = 16'h3020;
        mem[1]  = 16'h5004;
        mem[2]  = 16'h4040;
        mem[3]  = 16'h7003;
        mem[4]  = 16'h1021;
        mem[5]  = 16'h5002;
        mem[6]  = 16'h6008;
        mem[7]  = 16'h4041;
        mem[8]  = 16'h0022;
        mem[9]  = 16'h6002;
        mem[10] = 16'h5002;
        mem[11] = 16'h40FF;
        mem[12] = 16'hF000;
        mem[13] = 16'h4042;
        mem[14] = 16'h700E;
        mem['h20] = 16'h0000;
        mem['h21] = 16'h0001;
        mem['h22] = 16'h0002;
        mem['h40] = 16'hDEAD;
        mem['h41] = 16'hDEAD;
        run(150);
        for (int i = 0; i < 17; i++)
            chk(tr_addr[tr_base + i] == ea[i] && tr_we[tr_base + i] == (i == 14),
                "R7 branch access sequence", tr_addr[tr_base + i], ea[i]);
        chk(gap(2, 3) == 6, "R7 taken brz spacing", gap(2, 3), 6);
        chk(gap(5, 6) == 5, "R7 untaken brz spacing", gap(5, 6), 5);
        chk(gap(12, 13) == 5, "R3 undefined opcode spacing", gap(12, 13), 5);
        chk(mem['h40] == 16'hDEAD, "R7 skipped store", int'(mem['h40]), 'hDEAD);
        chk(mem['h41] == 16'hDEAD, "R7 skipped store brn", int'(mem['h41]), 'hDEAD);
        chk(mem['h42] == 16'h0001, "R3 noop keeps AC", int'(mem['h42]), 1);
        chk(disp_out == 16'h0001, "R9 display", int'(disp_out), 1);
    endtask

    task automatic t_display_load();
        int wff = 0;
        hold_reset();
        mem[0] = 16'h3020;
        mem[1] = 16'h40FF;
        mem[2] = 16'h3021;
        mem[3] = 16'h30FF;
        mem[4] = 16'h4030;
        mem[5] = 16'h7005;
        mem['h20] = 16'h80AB;
        mem['h21] = 16'h0000;
        mem['hFF] = 16'h5555;
        run(100);
        for (int i = tr_base; i < tr_n; i++) if (tr_we[i] && tr_addr[i] == 'hFF) wff++;
        chk(wff == 0, "R9 no write strobe at top", wff, 0);
        chk(mem['h30] == 16'h80AB, "R9 load returns display", int'(mem['h30]), 'h80AB);
        chk(mem['hFF] == 16'h5555, "R9 memory top unchanged", int'(mem['hFF]), 'h5555);
        chk(disp_out == 16'h80AB, "R5 load then display", int'(disp_out), 'h80AB);
    endtask

    task automatic t_neg_load();
        hold_reset();
        mem[0] = 16'h3020;
        mem[1] = 16'h6004;
        mem[2] = 16'h40FF;
        mem[3] = 16'h7003;
        mem[4] = 16'h3021;
        mem[5] = 16'h40FF;
        mem[6] = 16'h7006;
        mem['h20] = 16'h8000;
        mem['h21] = 16'h0777;
        run(80);
        chk(disp_out == 16'h0777, "R7 brn after negative load", int'(disp_out), 'h777);
        chk(tr_addr[tr_base + 3] == 4, "R5 R7 branch target", tr_addr[tr_base + 3], 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_arith();
        t_branch();
        t_display_load();
        t_neg_load();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule